// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block is the timed controller that brings one smart card contact set up and takes it down again. A host lowers an active-low session command to open a session and raises it to close one. From that command the block drives, in a fixed order, the card supply enable, the data line enable, the gate for the card clock and the card reset line. The rate of a slow internal oscillator, delivered as a one-cycle tick, sets every interval. One timing unit is a parameterised number of ticks, and all schedule points fall on half units.

The card clock can start in one of two ways. If the host reset input is low when the session opens, the clock starts together with the data line. If it is high, the clock waits until the host pulls that input low after the data line is enabled. After card reset is released, the card reset line follows the host reset input. A fault, a supply drop or a removed card during a session triggers the same shutdown order as a host close, with no host action. A low-power stop request is granted only while the interface is idle.

Top module: `card_seq_top`

## Requirements
- R1: After synchronous reset, `seq_state` is 0 (idle) and `vcc_en`, `io_en`, `clk_gate`, `card_rst` and `stop_ok` are all low.
- R2: A start needs four things together: a high-to-low transition of `sess_n`, `card_present` high, and both `fault` and `supply_drop` low. On the clock edge that sees the start, `vcc_en` rises and `seq_state` becomes 1 (activating). A falling `sess_n` with no card present leaves the block idle.
- R3: A half unit is UNIT_TICKS/2 ticks of `osc_tick`. `io_en` rises on the edge that completes 8 half units (4 units) after the start. On the edge that completes 14 half units (7 units), `seq_state` becomes 2 (active).
- R4: If `host_rst` is low on the start edge, `clk_gate` rises on the same edge as `io_en`.
- R5: If `host_rst` is high on the start edge, `clk_gate` rises on the first edge that sees `host_rst` low once 8 half units have elapsed, and no later than the edge that enters the active state. The `host_rst` input has no effect on `clk_gate` in any other state.
- R6: `card_rst` is low except in the active state. In the active state it equals `host_rst`.
- R7: A rising `sess_n` in the active state sets `seq_state` to 3 (deactivating), which drives `card_rst` low at once. `clk_gate` falls after 1 half unit, `io_en` after 2 half units, and `vcc_en` after 3 half units. On that last edge `seq_state` returns to 0.
- R8: If `fault` or `supply_drop` is high, or `card_present` is low, in the activating or active state, the block enters the deactivating state on the next edge and then follows the R7 order.
- R9: `stop_ok` is high exactly when `seq_state` is idle, `stop_req` is high and `sess_n` is high. A deactivation in progress is therefore completed before stop is granted.
- R10: If `sess_n` rises during activation, the block enters the deactivating state at once. The contact enables keep their present values until their R7 points, and none that is still off turns on.
- R11: If `sess_n` is held low after a shutdown, no new activation starts. A new session needs `sess_n` to rise and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per slow oscillator period |
| sess_n | input | 1 | Active-low session command from host |
| host_rst | input | 1 | Host reset request for the card |
| card_present | input | 1 | Debounced card presence, high when a card is inserted |
| fault | input | 1 | Overcurrent or overtemperature fault |
| supply_drop | input | 1 | Host supply below its threshold |
| stop_req | input | 1 | Low-power stop request |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card data line enable |
| clk_gate | output | 1 | Gate to the card clock divider |
| card_rst | output | 1 | Card reset contact level |
| seq_state | output | 2 | 0 idle, 1 activating, 2 active, 3 deactivating |
| stop_ok | output | 1 | Stop mode granted |

## Verification
The bench runs sessions that open with the host reset input low and with it high. These runs separate the start of the clock together with the data line from the later, host-timed start, and include a late start that never happens because the host holds reset high until after release. Sessions close by host command, by fault, by supply drop, by card removal and by an abort part-way through activation. These show that each cause gives the same shutdown order and that enables still off during an abort stay off. Further patterns try opening without a card, holding the command low after a shutdown, and requesting stop during a shutdown. These separate edge-triggered from level-triggered starts and show that stop is granted only after the shutdown ends.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ACT   = 2'd1,
        SEQ_ON    = 2'd2,
        SEQ_DEACT = 2'd3
    } seq_state_e;

    // half-unit counter width and schedule points (in half units)
    localparam int PH_W       = 4;
    localparam int IO_PH      = 8;   // data line enable, 4 units
    localparam int REL_PH     = 14;  // reset release, 7 units
    localparam int CLK_OFF_PH = 1;   // clock stop after close
    localparam int IO_OFF_PH  = 2;   // data line off after close
    localparam int VCC_OFF_PH = 3;   // supply off after close

    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
    } contacts_t;

    // true when the current half-unit step lands on point 'target'
    function automatic logic lands_on(input logic [PH_W-1:0] ph, input int target);
        return ph == PH_W'(target - 1);
    endfunction

endpackage

// File: rtl/card_seq_timebase.sv
module card_seq_timebase #(
    parameter int HALF_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic osc_tick,
    output logic step
);
    localparam int TK_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

    logic [TK_W-1:0] tk;

    assign step = run && osc_tick && (tk == TK_W'(HALF_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tk <= '0;
        end else if (run && osc_tick) begin
            tk <= step ? '0 : tk + 1'b1;
        end
    end
endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
    import card_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             sess_n,
    input  logic             host_rst,
    input  logic             card_present,
    input  logic             fault,
    input  logic             supply_drop,
    output seq_state_e       st,
    output logic [PH_W-1:0]  ph,
    output logic             early,
    output logic             go_act,
    output logic             leave
);
    logic sess_q;
    logic in_session;

    assign in_session = (st == SEQ_ACT) || (st == SEQ_ON);
    assign go_act = (st == SEQ_IDLE) && sess_q && !sess_n && card_present
                    && !fault && !supply_drop;
    assign leave  = in_session && (sess_n || fault || supply_drop || !card_present);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            ph     <= '0;
            early  <= 1'b0;
            sess_q <= 1'b1;
        end else begin
            sess_q <= sess_n;
            if (go_act) begin
                st    <= SEQ_ACT;
                ph    <= '0;
                early <= !host_rst;
            end else if (leave) begin
                st <= SEQ_DEACT;
                ph <= '0;
            end else if (step) begin
                ph <= ph + 1'b1;
                if (st == SEQ_ACT && lands_on(ph, REL_PH))
                    st <= SEQ_ON;
                else if (st == SEQ_DEACT && lands_on(ph, VCC_OFF_PH))
                    st <= SEQ_IDLE;
            end
        end
    end
endmodule

// File: rtl/card_seq_contacts.sv
module card_seq_contacts
    import card_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_state_e       st,
    input  logic [PH_W-1:0]  ph,
    input  logic             step,
    input  logic             early,
    input  logic             go_act,
    input  logic             leave,
    input  logic             host_rst,
    output contacts_t        con,
    output logic             card_rst
);
    assign card_rst = (st == SEQ_ON) && host_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            con <= '0;
        end else if (go_act) begin
            con <= '{vcc: 1'b1, io: 1'b0, clk: 1'b0};
        end else if (!leave) begin
            if (st == SEQ_ACT) begin
                if (step && lands_on(ph, IO_PH)) begin
                    con.io <= 1'b1;
                    if (early) con.clk <= 1'b1;
                end else if (ph >= PH_W'(IO_PH) && !host_rst) begin
                    con.clk <= 1'b1;
                end
            end else if (st == SEQ_DEACT && step) begin
                if (lands_on(ph, CLK_OFF_PH)) con.clk <= 1'b0;
                if (lands_on(ph, IO_OFF_PH))  con.io  <= 1'b0;
                if (lands_on(ph, VCC_OFF_PH)) con.vcc <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top
    import card_seq_pkg::*;
#(
    parameter int UNIT_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       sess_n,
    input  logic       host_rst,
    input  logic       card_present,
    input  logic       fault,
    input  logic       supply_drop,
    input  logic       stop_req,
    output logic       vcc_en,
    output logic       io_en,
    output logic       clk_gate,
    output logic       card_rst,
    output logic [1:0] seq_state,
    output logic       stop_ok
);
    localparam int HALF_TICKS = UNIT_TICKS / 2;

    seq_state_e      st;
    logic [PH_W-1:0] ph;
    logic            early, go_act, leave, step;
    contacts_t       con;

    card_seq_timebase #(.HALF_TICKS(HALF_TICKS)) u_tb (
        .clk(clk), .rst(rst),
        .clr(go_act || leave),
        .run(st == SEQ_ACT || st == SEQ_DEACT),
        .osc_tick(osc_tick), .step(step)
    );

    card_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .step(step), .sess_n(sess_n),
        .host_rst(host_rst), .card_present(card_present), .fault(fault),
        .supply_drop(supply_drop), .st(st), .ph(ph), .early(early),
        .go_act(go_act), .leave(leave)
    );

    card_seq_contacts u_con (
        .clk(clk), .rst(rst), .st(st), .ph(ph), .step(step), .early(early),
        .go_act(go_act), .leave(leave), .host_rst(host_rst),
        .con(con), .card_rst(card_rst)
    );

    assign vcc_en    = con.vcc;
    assign io_en     = con.io;
    assign clk_gate  = con.clk;
    assign seq_state = st;
    assign stop_ok   = (st == SEQ_IDLE) && stop_req && sess_n;
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       fault,
    input logic       card_present,
    input logic       vcc_en,
    input logic       io_en,
    input logic       clk_gate,
    input logic       card_rst,
    input logic [1:0] seq_state,
    input logic       stop_ok
);
    assert_io_needs_vcc_R3: assert property (@(posedge clk) disable iff (rst)
        io_en |-> vcc_en);

    assert_clk_needs_io_R4: assert property (@(posedge clk) disable iff (rst)
        clk_gate |-> io_en);

    assert_rst_only_active_R6: assert property (@(posedge clk) disable iff (rst)
        card_rst |-> seq_state == 2'd2);

    assert_stop_only_idle_R9: assert property (@(posedge clk) disable iff (rst)
        stop_ok |-> seq_state == 2'd0);

    assert_start_needs_card_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(vcc_en) |-> (seq_state == 2'd1) && $past(card_present));

    assert_vcc_off_last_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(vcc_en) |-> !io_en && !clk_gate);

    assert_fault_shutdown_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2 && fault) |=> seq_state == 2'd3);
endmodule

bind card_seq_top card_seq_chk u_chk (
    .clk(clk), .rst(rst), .fault(fault), .card_present(card_present),
    .vcc_en(vcc_en), .io_en(io_en), .clk_gate(clk_gate), .card_rst(card_rst),
    .seq_state(seq_state), .stop_ok(stop_ok)
);

// File: tb/sim_card_seq_top.sv
`timescale 1ns/1ps
module sim_card_seq_top;
    localparam int UNIT = 8;
    localparam int HALF = UNIT / 2;

    logic clk = 0, rst = 1;
    logic osc_tick = 0, sess_n = 1, host_rst = 0, card_present = 0;
    logic fault = 0, supply_drop = 0, stop_req = 0;
    logic vcc_en, io_en, clk_gate, card_rst, stop_ok;
    logic [1:0] seq_state;

    int checks = 0, failures = 0;
    bit done = 0, started = 0;

    always #2.5 clk = ~clk;

    card_seq_top #(.UNIT_TICKS(UNIT)) u0 (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .sess_n(sess_n),
        .host_rst(host_rst), .card_present(card_present), .fault(fault),
        .supply_drop(supply_drop), .stop_req(stop_req), .vcc_en(vcc_en),
        .io_en(io_en), .clk_gate(clk_gate), .card_rst(card_rst),
        .seq_state(seq_state), .stop_ok(stop_ok)
    );

    // oscillator tick: one cycle in three
    int tcnt = 0;
    always @(posedge clk) begin
        #1;
        tcnt++;
        osc_tick = (tcnt % 3 == 0);
    end

    // behavioural reference: mode and tick count since sequence start
    int m = 0, tc = 0;
    bit e_vcc = 0, e_io = 0, e_clk = 0, early = 0, prev_sess = 1;
    always @(posedge clk) begin
        int old;
        started = 1;
        if (rst) begin
            m = 0; tc = 0; e_vcc = 0; e_io = 0; e_clk = 0; prev_sess = 1;
        end else begin
            case (m)
                0: if (prev_sess && !sess_n && card_present && !fault && !supply_drop) begin
                       m = 1; tc = 0; early = !host_rst;
                       e_vcc = 1; e_io = 0; e_clk = 0;
                   end
                1, 2: if (sess_n || fault || supply_drop || !card_present) begin
                       m = 3; tc = 0;
                   end else if (m == 1) begin
                       old = tc;
                       if (osc_tick) tc++;
                       if (osc_tick && tc == 8*HALF) begin
                           e_io = 1; if (early) e_clk = 1;
                       end else if (old >= 8*HALF && !host_rst) e_clk = 1;
                       if (tc == 14*HALF) m = 2;
                   end
                3: if (osc_tick) begin
                       tc++;
                       if (tc == 1*HALF) e_clk = 0;
                       if (tc == 2*HALF) e_io = 0;
                       if (tc == 3*HALF) begin e_vcc = 0; m = 0; end
                   end
                default: m = 0;
            endcase
            prev_sess = sess_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R10 seq_state", seq_state, m);
            chk("R2 vcc_en", vcc_en, e_vcc);
            chk("R3 io_en", io_en, e_io);
            chk("R4 clk_gate", clk_gate, e_clk);
            chk("R6 card_rst", card_rst, (m == 2) && host_rst);
            chk("R9 stop_ok", stop_ok, (m == 0) && stop_req && sess_n);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_state(input int code);
        for (int i = 0; i < 2000; i++) begin
            if (seq_state == code) break;
            cyc(1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        @(negedge clk);
        chk("R1 reset state", seq_state, 0);
        chk("R1 reset contacts", {vcc_en, io_en, clk_gate, card_rst}, 0);
        cyc(1); rst = 0;
        cyc(4);

        // no card: falling command ignored
        sess_n = 0; cyc(30);
        chk("R2 no card stays idle", seq_state, 0);
        sess_n = 1; cyc(5);

        // early clock session, host close
        card_present = 1; host_rst = 0; cyc(2);
        sess_n = 0;
        wait_state(2);
        chk("R4 clock runs with early start", clk_gate, 1);
        host_rst = 1; cyc(10);
        chk("R6 card reset follows host", card_rst, 1);
        host_rst = 0; cyc(5);
        sess_n = 1;
        wait_state(0); cyc(2);
        chk("R7 close ends idle", {vcc_en, io_en, clk_gate}, 0);

        // late clock session, fault shutdown
        host_rst = 1; cyc(5);
        sess_n = 0; cyc(120);
        host_rst = 0; cyc(5);
        chk("R5 late clock started", clk_gate, 1);
        wait_state(2);
        host_rst = 1; cyc(6);
        fault = 1; cyc(2);
        chk("R8 fault shutdown", seq_state, 3);
        fault = 0;
        wait_state(0); cyc(40);
        chk("R11 held command no restart", seq_state, 0);
        sess_n = 1; cyc(5);

        // late start that never happens, then card removal
        host_rst = 1; sess_n = 0;
        wait_state(2);
        chk("R5 no clock without host low", clk_gate, 0);
        host_rst = 0; cyc(6);
        chk("R5 host low after release no clock", clk_gate, 0);
        card_present = 0; cyc(2);
        chk("R8 removal shutdown", seq_state, 3);
        wait_state(0);
        sess_n = 1; card_present = 1; cyc(5);

        // abort during activation before data line
        host_rst = 0; sess_n = 0; cyc(50);
        sess_n = 1; cyc(2);
        chk("R10 abort state", seq_state, 3);
        chk("R10 abort keeps io off", io_en, 0);
        stop_req = 1; cyc(2);
        chk("R9 stop held off in shutdown", stop_ok, 0);
        wait_state(0); cyc(2);
        chk("R9 stop granted idle", stop_ok, 1);
        stop_req = 0; cyc(3);

        // supply drop while active
        sess_n = 0;
        wait_state(2); cyc(4);
        supply_drop = 1; cyc(2);
        chk("R8 supply drop shutdown", seq_state, 3);
        supply_drop = 0; sess_n = 1;
        wait_state(0); cyc(5);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule